// File: doc/BRIEF.md
# Addressed Two-Wire Sensor Bus Slave

This block is the slave side of a two-wire serial sensor bus. The bus has a clock line and a data line, and both are open drain. The master drives the clock. All the slaves and the master share the data line as a wired-AND. The slave never drives a line high. Its only output to the bus, `data_pull_o`, enables a pull-down on the data line. The bus lines are brought into the system clock domain through synchronizers. The slave then watches them for a frame.

A frame begins with a start condition: the data line falls while the bus clock is high. Eight bits follow, sampled on rising bus clock edges, most significant bit first. The upper nibble is compared with the strapped chip address. On a match, the lower nibble becomes the photodiode select, and the slave hands the data line to its asynchronous frequency input. On a mismatch, it drops back to sleep. A sleeping slave ignores bus clock activity until it sees a start condition.

A slave can ask for attention in two ways:
- A service request holds the data line low. It may only be raised on a quiet bus, and it lasts until the master begins clocking.
- An interrupt is a fixed-length low pulse. It may be sent at any time, unless it is masked.

Top module: `sensor_bus_slave`

## Requirements
- R1: After reset, `data_pull_o`, `selected_o`, `awake_o` and `sel_o` are all 0.
- R2: A falling data line while the bus clock is high wakes the slave (`awake_o`=1) and opens a frame.
- R3: The slave samples 8 frame bits on rising bus clock edges, MSB first. When bits [7:4] equal `chip_addr_i`, it sets `selected_o`=1 and `sel_o`=bits [3:0].
- R4: When bits [7:4] differ from `chip_addr_i`, the slave returns to sleep (`awake_o`=0, `selected_o`=0) and `sel_o` keeps its earlier value.
- R5: While selected, `data_pull_o` is 1 exactly when `freq_i` is 0. There is no register between `freq_i` and `data_pull_o` in the default variant.
- R6: A start condition seen while selected clears `selected_o` and opens a new frame.
- R7: A held `srq_i` pulls the data line low only when the slave sleeps and both bus lines are high. During a frame it has no effect on `data_pull_o`.
- R8: A granted service request keeps `data_pull_o`=1 until the bus clock falls. The slave then releases the line and takes the following 8 bits as a frame.
- R9: With `irq_en_i`=1, a pulse on `irq_i` pulls the data line low for IRQ_CYC clock cycles (default 8). This happens in any state, including while selected.
- R10: With `irq_en_i`=0, a pulse on `irq_i` leaves `data_pull_o` at 0.
- R11: While the slave sleeps, bus clock edges and data changes made while the clock is low leave `awake_o` and `sel_o` unchanged.
- R12: A data-line fall caused by the slave's own pull-down is never taken as a start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Bus clock line level |
| bus_data_i | input | 1 | Bus data line level |
| data_pull_o | output | 1 | 1 enables the pull-down on the data line |
| freq_i | input | 1 | Light-to-frequency signal routed to the bus while selected |
| chip_addr_i | input | CHIP_W (4) | Strapped chip address |
| srq_i | input | 1 | Level request for service |
| irq_i | input | 1 | One-cycle interrupt event |
| irq_en_i | input | 1 | Interrupt enable (mask when 0) |
| sel_o | output | SEL_W (4) | Latched photodiode select |
| selected_o | output | 1 | Slave has been addressed and owns the data line |
| awake_o | output | 1 | Slave is out of sleep |

## Verification
A wrong frame state shows at the ports within a few system cycles of the eighth rising bus clock edge. It appears as a `selected_o` or `sel_o` value that differs from the address byte just sent, or as a slave that stays awake after a mismatch. A corrupt quiet-history or synchronizer state shows up differently. Either the slave wakes on its own interrupt pulse, or it misses the master's next start condition. Both cases are visible on `awake_o` one frame later. Faults in the request logic appear directly on `data_pull_o`: a pull during a frame, a pull that is never released after the clock falls, or a pulse of the wrong length.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic [1:0] {
      ST_SLEEP = 2'd0,
      ST_SRQ   = 2'd1,
      ST_RX    = 2'd2,
      ST_SEL   = 2'd3
   } sbs_state_e;
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sbs_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sbs_irq_gen.sv
module sbs_irq_gen #(
   parameter int IRQ_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_i,
   input  logic en_i,
   output logic active_o
);
   if (IRQ_CYC < 1) begin : g_bad_len
      $error("sbs_irq_gen: IRQ_CYC must be at least 1");
   end

   localparam int CW = $clog2(IRQ_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(IRQ_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (irq_i && en_i)  cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = (cnt_q != '0);

   // R10: a masked event never starts a pulse
   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> $past(en_i && irq_i));
   // R9: a running pulse only ends after counting down, never restarts by itself
   assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !(irq_i && en_i) && cnt_q > 1) |=> active_o);
endmodule

// File: rtl/sbs_frame_rx.sv
module sbs_frame_rx
   import sbs_pkg::*;
#(
   parameter int CHIP_W = 4,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_s,
   input  logic              data_s,
   input  logic              quiet_i,
   input  logic              srq_i,
   input  logic [CHIP_W-1:0] chip_addr_i,
   output sbs_state_e        st_o,
   output logic [SEL_W-1:0]  sel_o
);
   localparam int FRAME_W = CHIP_W + SEL_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   sbs_state_e         st_q;
   logic               clk_d, data_d;
   logic [FRAME_W-1:0] shreg_q;
   logic [FRAME_W-1:0] frame_w;
   logic [CNT_W-1:0]   cnt_q;
   logic [SEL_W-1:0]   sel_q;
   logic               clk_rise, clk_fall, data_fall, start;
   logic               bus_quiet;

   assign clk_rise  = clk_s && !clk_d;
   assign clk_fall  = !clk_s && clk_d;
   assign data_fall = !data_s && data_d;
   assign start     = data_fall && clk_s && quiet_i;
   assign bus_quiet = clk_s && data_s && quiet_i;
   assign frame_w   = {shreg_q[FRAME_W-2:0], data_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_d  <= 1'b1;
         data_d <= 1'b1;
      end else begin
         clk_d  <= clk_s;
         data_d <= data_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_SLEEP;
         cnt_q   <= '0;
         shreg_q <= '0;
         sel_q   <= '0;
      end else if (start) begin
         st_q  <= ST_RX;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_SLEEP: if (srq_i && bus_quiet) st_q <= ST_SRQ;
            ST_SRQ: if (clk_fall) begin
               st_q  <= ST_RX;
               cnt_q <= '0;
            end
            ST_RX: if (clk_rise) begin
               shreg_q <= frame_w;
               cnt_q   <= cnt_q + 1'b1;
               if (cnt_q == LAST) begin
                  if (frame_w[FRAME_W-1:SEL_W] == chip_addr_i) begin
                     sel_q <= frame_w[SEL_W-1:0];
                     st_q  <= ST_SEL;
                  end else begin
                     st_q  <= ST_SLEEP;
                  end
               end
            end
            ST_SEL: st_q <= ST_SEL;
            default: st_q <= ST_SLEEP;
         endcase
      end
   end

   assign st_o  = st_q;
   assign sel_o = sel_q;

   // R7: a service request is only entered from sleep on a quiet bus
   assert_srq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SRQ && $past(st_q) != ST_SRQ) |-> $past(st_q == ST_SLEEP && clk_s && data_s));
   // R4: the select only moves on a sampling edge of an open frame
   assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_q) |-> $past(st_q == ST_RX && clk_rise));
   // R8: a falling bus clock ends the service request in one cycle
   assert_srq_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SRQ && clk_fall) |=> (st_q == ST_RX));
   // R11: a sleeping slave without start never enters the frame or selected state
   assert_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SLEEP && !start) |=> (st_q == ST_SLEEP || st_q == ST_SRQ));
endmodule

// File: rtl/sensor_bus_slave.sv
module sensor_bus_slave
   import sbs_pkg::*;
#(
   parameter int CHIP_W      = 4,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int IRQ_CYC     = 8,
   parameter bit FREQ_SYNC   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_clk_i,
   input  logic              bus_data_i,
   output logic              data_pull_o,
   input  logic              freq_i,
   input  logic [CHIP_W-1:0] chip_addr_i,
   input  logic              srq_i,
   input  logic              irq_i,
   input  logic              irq_en_i,
   output logic [SEL_W-1:0]  sel_o,
   output logic              selected_o,
   output logic              awake_o
);
   if (CHIP_W < 1 || SEL_W < 1) begin : g_bad_fields
      $error("sensor_bus_slave: address fields must be non-empty");
   end

   localparam int QUIET_LEN = SYNC_STAGES + 2;

   logic [1:0]           bus_s;
   logic                 freq_w;
   logic                 irq_active;
   logic                 quiet;
   logic [QUIET_LEN-1:0] own_hist_q;
   sbs_state_e           st;

   sbs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d_i({bus_clk_i, bus_data_i}), .q_o(bus_s)
   );

   if (FREQ_SYNC) begin : g_freq_sync
      logic [0:0] fq;
      sbs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_freq_sync (
         .clk(clk), .rst_n(rst_n), .d_i(freq_i), .q_o(fq)
      );
      assign freq_w = fq[0];
   end else begin : g_freq_direct
      assign freq_w = freq_i;
   end

   sbs_frame_rx #(.CHIP_W(CHIP_W), .SEL_W(SEL_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .clk_s(bus_s[1]), .data_s(bus_s[0]), .quiet_i(quiet),
      .srq_i(srq_i), .chip_addr_i(chip_addr_i),
      .st_o(st), .sel_o(sel_o)
   );

   sbs_irq_gen #(.IRQ_CYC(IRQ_CYC)) u_irq (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .en_i(irq_en_i),
      .active_o(irq_active)
   );

   assign data_pull_o = irq_active || (st == ST_SRQ) || ((st == ST_SEL) && !freq_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) own_hist_q <= '0;
      else        own_hist_q <= {own_hist_q[QUIET_LEN-2:0], data_pull_o};
   end

   assign quiet      = (own_hist_q == '0) && !data_pull_o;
   assign selected_o = (st == ST_SEL);
   assign awake_o    = (st != ST_SLEEP);

   // R12: our own recent pull never opens a frame
   assert_own_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(data_pull_o) && st == ST_RX && $past(st) != ST_RX) |-> $past(st) == ST_SRQ);
   // R10: a sleeping slave with no pulse and no request leaves the line alone
   assert_sleep_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SLEEP && !irq_active) |-> !data_pull_o);
endmodule

// File: tb/sensor_bus_slave_tb.sv
module sensor_bus_slave_tb;
   localparam logic [3:0] CHIP = 4'hA;
   localparam int IRQ_CYC = 8;
   // vector: {frame byte, expected sel, expected selected}
   localparam logic [12:0] VEC [6] = '{
      {8'hA3, 4'h3, 1'b1},
      {8'h57, 4'h3, 1'b0},
      {8'hAF, 4'hF, 1'b1},
      {8'h0A, 4'hF, 1'b0},
      {8'hA0, 4'h0, 1'b1},
      {8'hAC, 4'hC, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic mclk = 1'b1, mdata = 1'b1, freq = 1'b1;
   logic srq = 1'b0, irq = 1'b0, irq_en = 1'b0;
   logic bus_data, pull, selected, awake;
   logic [3:0] sel;
   int errs = 0, checks = 0;

   always #10 clk = ~clk;
   assign bus_data = mdata & ~pull;

   sensor_bus_slave u_dut (
      .clk(clk), .rst_n(rst_n), .bus_clk_i(mclk), .bus_data_i(bus_data),
      .data_pull_o(pull), .freq_i(freq), .chip_addr_i(CHIP),
      .srq_i(srq), .irq_i(irq), .irq_en_i(irq_en),
      .sel_o(sel), .selected_o(selected), .awake_o(awake)
   );

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      mclk = 1'b1; mdata = 1'b1; w(8);
      mdata = 1'b0; w(8);
      mclk = 1'b0; w(4);
   endtask

   task automatic send_bits(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         mdata = b[i]; w(8);
         mclk = 1'b1; w(8);
         if (i != 0) begin mclk = 1'b0; w(4); end
      end
      mdata = 1'b1; w(10);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      w(3);
      chk("R1 pull", pull, 0); chk("R1 selected", selected, 0);
      chk("R1 awake", awake, 0); chk("R1 sel", sel, 0);
      rst_n = 1'b1; w(6);

      // R2: start wakes the slave
      bus_start();
      chk("R2 awake after start", awake, 1);
      send_bits(8'hA5);
      chk("R3 selected", selected, 1); chk("R3 sel", sel, 4'h5);

      // table walk: R3 match, R4 mismatch keeps sel
      foreach (VEC[k]) begin
         bus_start();
         send_bits(VEC[k][12:5]);
         chk(VEC[k][0] ? "R3 sel" : "R4 sel kept", sel, VEC[k][4:1]);
         chk(VEC[k][0] ? "R3 selected" : "R4 not selected", selected, VEC[k][0]);
         chk(VEC[k][0] ? "R3 awake" : "R4 asleep", awake, VEC[k][0]);
      end

      // R5: frequency routed while selected
      freq = 1'b0; #1 chk("R5 pull on freq low", pull, 1);
      w(3); freq = 1'b1; #1 chk("R5 release on freq high", pull, 0);
      w(3); freq = 1'b0; #1 chk("R5 pull again", pull, 1);
      w(2); freq = 1'b1; w(6);

      // R9 and R12: interrupt while selected, own edge not a start
      irq_en = 1'b1; irq = 1'b1; w(1); irq = 1'b0; w(1);
      chk("R9 pull while selected", pull, 1);
      w(IRQ_CYC + 2);
      chk("R9 pulse ended", pull, 0);
      chk("R12 still selected", selected, 1);

      // R6: new start deselects
      bus_start();
      chk("R6 deselected", selected, 0); chk("R6 awake", awake, 1);
      // R7: request during a frame has no effect
      srq = 1'b1; w(6);
      chk("R7 no pull in frame", pull, 0);
      srq = 1'b0;
      send_bits(8'h51);
      chk("R4 sel kept after mismatch", sel, 4'hC);
      chk("R4 asleep", awake, 0);

      // R11: clock activity while asleep
      for (int k = 0; k < 4; k++) begin
         mclk = 1'b0; w(4); mdata = k[0]; w(4); mclk = 1'b1; w(8);
      end
      mdata = 1'b1; w(8);
      chk("R11 still asleep", awake, 0); chk("R11 sel unchanged", sel, 4'hC);

      // R9 and R12 in sleep
      irq = 1'b1; w(1); irq = 1'b0; w(1);
      chk("R9 pull in sleep", pull, 1);
      w(IRQ_CYC - 3); chk("R9 pull held", pull, 1);
      w(6); chk("R9 released", pull, 0);
      chk("R12 no wake from own pulse", awake, 0);

      // R10: masked interrupt
      irq_en = 1'b0; irq = 1'b1; w(1); irq = 1'b0;
      for (int k = 0; k < 4; k++) begin w(2); chk("R10 masked", pull, 0); end

      // R7 and R8: granted service request
      srq = 1'b1; w(8);
      chk("R7 pull on quiet bus", pull, 1); chk("R7 awake", awake, 1);
      srq = 1'b0; w(4);
      chk("R8 held", pull, 1);
      mclk = 1'b0; w(6);
      chk("R8 released after clock fall", pull, 0);
      send_bits(8'hA6);
      chk("R8 frame selected", selected, 1); chk("R8 sel", sel, 4'h6);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule